// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block holds a small set of recent page translations, and any slot can hold any page. A lookup gives a virtual address, an address-space tag and a read/write flag. One cycle later the block answers with a hit, a miss or a protection fault. On a hit it also returns the physical address and the entry's usage bits as they stood before that lookup. A miss tells an external page-table walker, or a software handler, to supply the translation.

Each entry has its own page-size code, so small and large pages share the array. Entries are installed through a fill port. A fill first reuses an entry that already maps the same page in the same address space. If there is none, it takes a free slot. If the array is full, it evicts the slot named by a rotating pointer. A flush port removes every entry, or only the entries of one address space, for use on a context switch.

Top module: `tlb_assoc`

## Requirements
- R1: After reset, every entry is invalid, `rsp_valid` is low and any lookup reports a miss.
- R2: `rsp_valid` rises exactly one cycle after `lk_valid`. A lookup reports a miss (hit 0, fault 0, address and usage bits 0) when no valid entry matches its page and its tag.
- R3: A hit also requires the entry's address-space tag to equal `lk_asid`. The same page under a different tag misses.
- R4: Page-size code s is one of 0 (4 KB), 1 (16 KB), 2 (64 KB) or 3 (256 KB). The tag compare ignores the low 2*s bits of the virtual page number. The physical address takes its bits above 12+2*s from the entry's page number and its low 12+2*s bits from the virtual address.
- R5: A write lookup that hits an entry whose write-permission bit is clear returns hit=1 and fault=1. It leaves that entry's referenced and modified bits unchanged.
- R6: `rsp_ref` and `rsp_mod` report the entry's bits from before the lookup. A hit that does not fault sets referenced, and a write hit that does not fault also sets modified. Both changes are visible to the next lookup.
- R7: A fill with no matching entry goes to the lowest-numbered invalid slot. When all slots are valid, it replaces the slot named by a pointer that starts at 0 and advances by one, wrapping, on each such replacement.
- R8: A fill whose page and tag match a valid entry (compared under that entry's size) rewrites that entry in place, and no other slot is used.
- R9: A flush with `flush_all`=1 invalidates every entry by the next cycle.
- R10: A flush with `flush_all`=0 invalidates only the entries whose tag equals `flush_asid`.
- R11: A fill presented in the same cycle as a flush is dropped.
- R12: A newly filled entry starts with referenced and modified clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_fault | output | 1 | Write to an entry without write permission |
| rsp_paddr | output | PA_W | Translated physical address (0 on miss) |
| rsp_ref | output | 1 | Entry's referenced bit before this lookup |
| rsp_mod | output | 1 | Entry's modified bit before this lookup |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | VA_W-OFF_W | Virtual page number to install |
| fill_asid | input | ASID_W | Tag of the installed entry |
| fill_ppn | input | PA_W-OFF_W | Physical page number to install |
| fill_size | input | 2 | Page-size code (see R4) |
| fill_writable | input | 1 | Write permission of the installed entry |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | 1 = all entries, 0 = entries tagged `flush_asid` |
| flush_asid | input | ASID_W | Tag selected by a tag-only flush |

## Verification
On every cycle, the assertions check the response timing and that a miss carries no address or usage bits. They also check that a fault always comes with a hit and from a write, that a full flush and a tag-only flush leave no matching valid entry, that a fresh fill starts clean, and that a victim taken from a non-full array was free. Several behaviours can only be shown by the bench's ordered scenarios. These are the effect of the size mask on matching and address assembly, the referenced and modified history across successive lookups, duplicate-fill reuse, the round-robin eviction order, and a dropped fill during a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int unsigned SZ_BITS = 2;

   typedef logic [SZ_BITS-1:0] pgsz_t;

   // Mask with the low (size code * step) bits set; these page bits are
   // taken from the virtual address instead of being compared.
   function automatic logic [63:0] low_mask(pgsz_t sz, int unsigned step);
      logic [63:0] m;
      m = '0;
      for (int unsigned b = 0; b < 64; b++) begin
         if (b < (32'(sz) * step)) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/tlb_cam_line.sv
module tlb_cam_line #(
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 20,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned SZ_STEP = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [VPN_W-1:0]     lk_vpn,
   input  logic [ASID_W-1:0]    lk_asid,
   output logic                 match_o,
   input  logic [VPN_W-1:0]     fl_vpn,
   input  logic [ASID_W-1:0]    fl_asid,
   output logic                 dup_o,
   input  logic                 fill_we,
   input  logic [PPN_W-1:0]     fill_ppn,
   input  tlb_pkg::pgsz_t       fill_sz,
   input  logic                 fill_wr,
   input  logic                 flush_go,
   input  logic                 flush_all,
   input  logic [ASID_W-1:0]    flush_asid,
   input  logic                 set_ref,
   input  logic                 set_mod,
   output logic                 valid_o,
   output logic [PPN_W-1:0]     ppn_o,
   output tlb_pkg::pgsz_t       sz_o,
   output logic                 wr_o,
   output logic                 ref_o,
   output logic                 mod_o
);

   logic                 valid_q, wr_q, ref_q, mod_q;
   logic [VPN_W-1:0]     vpn_q;
   logic [ASID_W-1:0]    asid_q;
   logic [PPN_W-1:0]     ppn_q;
   tlb_pkg::pgsz_t       sz_q;
   logic [63:0]          lm;
   logic [VPN_W-1:0]     keep;
   logic                 flush_clr;

   assign lm   = tlb_pkg::low_mask(sz_q, SZ_STEP);
   assign keep = ~lm[VPN_W-1:0];

   assign match_o = valid_q && (asid_q == lk_asid) && (((lk_vpn ^ vpn_q) & keep) == '0);
   assign dup_o   = valid_q && (asid_q == fl_asid) && (((fl_vpn ^ vpn_q) & keep) == '0);

   assign flush_clr = flush_go && (flush_all || (asid_q == flush_asid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         wr_q    <= 1'b0;
         ref_q   <= 1'b0;
         mod_q   <= 1'b0;
         vpn_q   <= '0;
         asid_q  <= '0;
         ppn_q   <= '0;
         sz_q    <= '0;
      end else if (flush_clr) begin
         valid_q <= 1'b0;
      end else if (fill_we) begin
         valid_q <= 1'b1;
         vpn_q   <= fl_vpn;
         asid_q  <= fl_asid;
         ppn_q   <= fill_ppn;
         sz_q    <= fill_sz;
         wr_q    <= fill_wr;
         ref_q   <= 1'b0;
         mod_q   <= 1'b0;
      end else begin
         if (set_ref) ref_q <= 1'b1;
         if (set_mod) mod_q <= 1'b1;
      end
   end

   assign valid_o = valid_q;
   assign ppn_o   = ppn_q;
   assign sz_o    = sz_q;
   assign wr_o    = wr_q;
   assign ref_o   = ref_q;
   assign mod_o   = mod_q;

   // R12: a fresh entry starts clean
   p_fill_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && !flush_go) |=> (valid_o && !ref_o && !mod_o));

   // R10: a tag-only flush leaves no valid entry with that tag
   p_flush_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_go && !flush_all && valid_o && (asid_q == flush_asid)) |=> !valid_o);

   // R6: usage bits never clear while the entry stays in place
   p_ref_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_o && !fill_we) |=> (ref_o || !valid_o));

endmodule

// File: rtl/tlb_slot_pick.sv
module tlb_slot_pick #(
   parameter int unsigned ENTRIES = 128,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] dup_vec,
   output logic [IDX_W-1:0]   slot_o
);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] dup_idx, free_idx;
   logic             any_dup, full;

   assign any_dup = |dup_vec;
   assign full    = &valid_vec;

   always_comb begin
      dup_idx  = '0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (dup_vec[i])    dup_idx  = IDX_W'(i);
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (any_dup)    slot_o = dup_idx;
      else if (!full) slot_o = free_idx;
      else            slot_o = rr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fill_go && !any_dup && full) begin
         rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R7: a victim chosen while the array is not full is a free slot
   p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && !any_dup && !full) |-> !valid_vec[slot_o]);

   // R7: the rotating pointer stays inside the array
   p_rr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rr_q) < ENTRIES);

   // R8: a duplicate match always names a matching slot
   p_dup_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && any_dup) |-> dup_vec[slot_o]);

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 32,
   parameter int unsigned OFF_W   = 12,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned SZ_STEP = 2,
   localparam int unsigned VPN_W  = VA_W - OFF_W,
   localparam int unsigned PPN_W  = PA_W - OFF_W,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_ref,
   output logic              rsp_mod,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [1:0]        fill_size,
   input  logic              fill_writable,
   input  logic              flush_valid,
   input  logic              flush_all,
   input  logic [ASID_W-1:0] flush_asid
);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_chk_entries
      $error("tlb_assoc: ENTRIES must be at least 2");
   end
   if (VPN_W > 64 || PPN_W > 64) begin : g_chk_wide
      $error("tlb_assoc: page numbers wider than 64 bits");
   end
   if (VPN_W < 3 * SZ_STEP || PPN_W < 3 * SZ_STEP) begin : g_chk_narrow
      $error("tlb_assoc: page numbers too narrow for the largest page size");
   end
   if (ASID_W < 1) begin : g_chk_asid
      $error("tlb_assoc: ASID_W must be positive");
   end

   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] e_match, e_dup, e_valid, e_wr, e_ref, e_mod;
   logic [ENTRIES-1:0] e_fill_we, e_set_ref, e_set_mod;
   logic [PPN_W-1:0]   e_ppn [ENTRIES];
   tlb_pkg::pgsz_t     e_sz  [ENTRIES];
   logic [IDX_W-1:0]   hit_idx, fill_slot;
   logic               any_hit, fault_now, fill_go;
   logic [63:0]        sel_lm, vpn64;
   logic [PPN_W-1:0]   pmask, out_ppn;
   logic [PA_W-1:0]    pa_now;

   assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
   assign fill_go = fill_valid && !flush_valid;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_line
      assign e_fill_we[g] = fill_go && (fill_slot == IDX_W'(g));
      assign e_set_ref[g] = lk_valid && any_hit && (hit_idx == IDX_W'(g)) && !fault_now;
      assign e_set_mod[g] = e_set_ref[g] && lk_write;

      tlb_cam_line #(
         .VPN_W  (VPN_W),
         .PPN_W  (PPN_W),
         .ASID_W (ASID_W),
         .SZ_STEP(SZ_STEP)
      ) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .lk_vpn    (lk_vpn),
         .lk_asid   (lk_asid),
         .match_o   (e_match[g]),
         .fl_vpn    (fill_vpn),
         .fl_asid   (fill_asid),
         .dup_o     (e_dup[g]),
         .fill_we   (e_fill_we[g]),
         .fill_ppn  (fill_ppn),
         .fill_sz   (fill_size),
         .fill_wr   (fill_writable),
         .flush_go  (flush_valid),
         .flush_all (flush_all),
         .flush_asid(flush_asid),
         .set_ref   (e_set_ref[g]),
         .set_mod   (e_set_mod[g]),
         .valid_o   (e_valid[g]),
         .ppn_o     (e_ppn[g]),
         .sz_o      (e_sz[g]),
         .wr_o      (e_wr[g]),
         .ref_o     (e_ref[g]),
         .mod_o     (e_mod[g])
      );
   end

   tlb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_go  (fill_go),
      .valid_vec(e_valid),
      .dup_vec  (e_dup),
      .slot_o   (fill_slot)
   );

   // lowest-numbered matching entry wins
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (e_match[i]) hit_idx = IDX_W'(i);
      end
   end

   assign any_hit   = |e_match;
   assign fault_now = any_hit && lk_write && !e_wr[hit_idx];

   assign sel_lm  = tlb_pkg::low_mask(e_sz[hit_idx], SZ_STEP);
   assign pmask   = sel_lm[PPN_W-1:0];
   assign vpn64   = 64'(lk_vpn);
   assign out_ppn = (e_ppn[hit_idx] & ~pmask) | (vpn64[PPN_W-1:0] & pmask);
   assign pa_now  = {out_ppn, lk_vaddr[OFF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
         rsp_ref   <= 1'b0;
         rsp_mod   <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && any_hit;
         rsp_fault <= lk_valid && fault_now;
         rsp_paddr <= (lk_valid && any_hit) ? pa_now : '0;
         rsp_ref   <= lk_valid && any_hit && e_ref[hit_idx];
         rsp_mod   <= lk_valid && any_hit && e_mod[hit_idx];
      end
   end

   // R2: one response per request, one cycle later
   p_resp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);

   // R2: a miss carries no address and no usage bits
   p_miss_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_ref && !rsp_mod && !rsp_fault));

   // R5: a fault is always a hit caused by a write
   p_fault_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_hit && $past(lk_write)));

   // R9: a full flush empties the array
   p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && flush_all) |=> (e_valid == '0));

endmodule

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_ref, rsp_mod;
   logic [31:0] rsp_paddr;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [7:0]  fill_asid = '0;
   logic [19:0] fill_ppn = '0;
   logic [1:0]  fill_size = '0;
   logic        fill_writable = 1'b0;
   logic        flush_valid = 1'b0;
   logic        flush_all = 1'b0;
   logic [7:0]  flush_asid = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic        hit;
      logic        fault;
      logic [31:0] pa;
      logic        rf;
      logic        md;
      string       tag;
   } exp_t;

   exp_t expq[$];

   always #5 clk = ~clk;

   tlb_assoc #(.ENTRIES(4)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref), .rsp_mod(rsp_mod),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_writable(fill_writable),
      .flush_valid(flush_valid), .flush_all(flush_all), .flush_asid(flush_asid)
   );

   function automatic logic [31:0] xpa(logic [19:0] ppn, int sz, logic [31:0] va);
      logic [19:0] m;
      m = 20'((1 << (2 * sz)) - 1);
      return {(ppn & ~m) | (va[31:12] & m), va[11:0]};
   endfunction

   task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                       input logic eh, input logic ef, input logic [31:0] epa,
                       input logic er, input logic em, input string tag);
      exp_t e;
      e.hit = eh; e.fault = ef; e.pa = eh ? epa : 32'h0;
      e.rf = eh ? er : 1'b0; e.md = eh ? em : 1'b0; e.tag = tag;
      expq.push_back(e);
      @(posedge clk); #1;
      lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
      @(posedge clk); #1;
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic miss(input logic [31:0] va, input logic [7:0] asid, input string tag);
      look(va, asid, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn,
                       input logic [1:0] sz, input logic wr);
      @(posedge clk); #1;
      fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
      fill_ppn = ppn; fill_size = sz; fill_writable = wr;
      @(posedge clk); #1;
      fill_valid = 1'b0;
   endtask

   task automatic flush(input logic all, input logic [7:0] asid);
      @(posedge clk); #1;
      flush_valid = 1'b1; flush_all = all; flush_asid = asid;
      @(posedge clk); #1;
      flush_valid = 1'b0;
   endtask

   // monitor: compare each response with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         total++;
         if (expq.size() == 0) begin
            bad++;
            $display("FAIL R2: unexpected response hit=%0b", rsp_hit);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (rsp_hit !== e.hit || rsp_fault !== e.fault || rsp_paddr !== e.pa ||
                rsp_ref !== e.rf || rsp_mod !== e.md) begin
               bad++;
               $display("FAIL %s: got hit=%0b fault=%0b pa=%h ref=%0b mod=%0b, expected hit=%0b fault=%0b pa=%h ref=%0b mod=%0b",
                        e.tag, rsp_hit, rsp_fault, rsp_paddr, rsp_ref, rsp_mod,
                        e.hit, e.fault, e.pa, e.rf, e.md);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
         bad++;
         $display("FAIL R1: got rsp_valid=%0b rsp_hit=%0b, expected 0 0", rsp_valid, rsp_hit);
      end
      miss(32'h1234_5678, 8'd1, "R1 empty lookup");

      // entry A, small page, writable
      fill(20'h00010, 8'd1, 20'h00AB0, 2'd0, 1'b1);
      look(32'h0001_0123, 8'd1, 1'b0, 1, 0, 32'h00AB_0123, 0, 0, "R2 R12 first hit");
      look(32'h0001_0123, 8'd1, 1'b1, 1, 0, 32'h00AB_0123, 1, 0, "R6 ref after read");
      look(32'h0001_0123, 8'd1, 1'b0, 1, 0, 32'h00AB_0123, 1, 1, "R6 mod after write");
      miss(32'h0001_0123, 8'd2, "R3 tag mismatch");

      // entry B, 256 KB page, read only
      fill(20'h00400, 8'd1, 20'h12340, 2'd3, 1'b0);
      look(32'h0042_A5C3, 8'd1, 1'b0, 1, 0, xpa(20'h12340, 3, 32'h0042_A5C3), 0, 0, "R4 large page hit");
      miss(32'h0044_05C3, 8'd1, "R4 large page outside");

      // entry C, 16 KB page, read only
      fill(20'h00800, 8'd1, 20'h55550, 2'd1, 1'b0);
      look(32'h0080_3ABC, 8'd1, 1'b1, 1, 1, xpa(20'h55550, 1, 32'h0080_3ABC), 0, 0, "R5 write fault");
      look(32'h0080_3ABC, 8'd1, 1'b0, 1, 0, 32'h5555_3ABC, 0, 0, "R5 bits untouched by fault");
      look(32'h0080_0000, 8'd1, 1'b0, 1, 0, 32'h5555_0000, 1, 0, "R6 ref set by read");
      miss(32'h0080_4000, 8'd1, "R4 medium page outside");

      // refill A in place
      fill(20'h00010, 8'd1, 20'h0BEEF, 2'd0, 1'b1);
      look(32'h0001_0123, 8'd1, 1'b0, 1, 0, 32'h0BEE_F123, 0, 0, "R8 R12 rewritten entry");

      // D fills last free slot; E evicts slot 0 (A)
      fill(20'h00020, 8'd2, 20'h00D00, 2'd0, 1'b1);
      look(32'h0002_0010, 8'd2, 1'b0, 1, 0, 32'h00D0_0010, 0, 0, "R7 free slot fill");
      fill(20'h00030, 8'd3, 20'h00E00, 2'd0, 1'b1);
      miss(32'h0001_0123, 8'd1, "R7 first eviction slot 0");
      look(32'h0042_A5C3, 8'd1, 1'b0, 1, 0, 32'h1236_A5C3, 1, 0, "R8 no extra slot used");

      // F evicts slot 1 (B)
      fill(20'h00040, 8'd2, 20'h00F00, 2'd0, 1'b1);
      miss(32'h0042_A5C3, 8'd1, "R7 second eviction slot 1");
      look(32'h0004_0008, 8'd2, 1'b0, 1, 0, 32'h00F0_0008, 0, 0, "R7 new entry present");

      // tag-only flush of tag 2
      flush(1'b0, 8'd2);
      miss(32'h0002_0010, 8'd2, "R10 tag flush D");
      miss(32'h0004_0008, 8'd2, "R10 tag flush F");
      look(32'h0080_0000, 8'd1, 1'b0, 1, 0, 32'h5555_0000, 1, 0, "R10 other tag kept C");
      look(32'h0003_0000, 8'd3, 1'b0, 1, 0, 32'h00E0_0000, 0, 0, "R10 other tag kept E");

      // fill during flush is dropped
      @(posedge clk); #1;
      flush_valid = 1'b1; flush_all = 1'b0; flush_asid = 8'd9;
      fill_valid = 1'b1; fill_vpn = 20'h00050; fill_asid = 8'd1;
      fill_ppn = 20'h00C50; fill_size = 2'd0; fill_writable = 1'b1;
      @(posedge clk); #1;
      flush_valid = 1'b0; fill_valid = 1'b0;
      miss(32'h0005_0000, 8'd1, "R11 fill dropped");

      // free slots 1 then 3; then pointer (at 2) evicts C
      fill(20'h00050, 8'd1, 20'h00C50, 2'd0, 1'b1);
      fill(20'h00060, 8'd1, 20'h00C60, 2'd0, 1'b1);
      fill(20'h00070, 8'd1, 20'h00C70, 2'd0, 1'b1);
      miss(32'h0080_0000, 8'd1, "R7 pointer eviction slot 2");
      look(32'h0005_0000, 8'd1, 1'b0, 1, 0, 32'h00C5_0000, 0, 0, "R7 slot 1 refilled");
      look(32'h0006_0000, 8'd1, 1'b0, 1, 0, 32'h00C6_0000, 0, 0, "R7 slot 3 refilled");
      look(32'h0007_0000, 8'd1, 1'b0, 1, 0, 32'h00C7_0000, 0, 0, "R7 replacement entry");
      look(32'h0003_0000, 8'd3, 1'b0, 1, 0, 32'h00E0_0000, 1, 0, "R7 slot 0 kept");

      // full flush
      flush(1'b1, 8'd0);
      miss(32'h0003_0000, 8'd3, "R9 full flush E");
      miss(32'h0007_0000, 8'd1, "R9 full flush I");

      repeat (3) @(posedge clk);
      total++;
      if (expq.size() != 0) begin
         bad++;
         $display("FAIL R2: got %0d missing responses, expected 0", expq.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule